// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a byte-wide requester and a memory that moves whole 32-bit blocks. A byte address is split into a tag, a set index and a two-bit byte lane. The set index picks one set of two ways. Each way keeps its own tag, valid flag, dirty flag and recency bit. Both stored tags are compared in the same cycle. A match in either way is a hit, and the block is free to sit in either way.

On a miss, a free way is taken first. If no way is free, the way that was not touched most recently is taken. If that victim holds modified data, it is written out to memory before the new block is read in. Writes allocate on a miss, then merge the byte and mark the block dirty. Every access that completes, read or write, marks its way as most recent and the sibling way as older.

The full-size configuration splits the address as 9 tag bits, 13 set bits and 2 lane bits. The set width is a parameter, so a small cache can be built to force conflicts and thrashing.

Top module: `c2w_cache`

## Requirements
- R1: Bits [1:0] of the address select the byte lane of the 32-bit block. Lane n is bits [8n+7:8n]. The next SET_W bits pick the set, and the remaining upper bits form the tag.
- R2: A read that hits returns the stored byte with resp_valid two cycles after the request is accepted, and issues no memory transfer.
- R3: A read miss issues a block read with mem_we low at block address req_addr[23:2], holds mem_req and mem_addr until mem_ack, and then returns the requested byte of the fetched block.
- R4: Two blocks whose addresses have the same set index and different tags are held together. After both are loaded, accesses to either one cause no memory transfer.
- R5: A miss in a set that still has an invalid way fills that way. It evicts no valid block and writes nothing back.
- R6: When both ways are valid, a miss replaces the way that was not accessed most recently. A hit, a write hit and a refill all count as accesses.
- R7: A write hit stores the byte into its lane without any memory transfer, and later reads return the new value.
- R8: A modified victim is written back with mem_we high at its own block address, with its current data. This happens before the block read for the new address.
- R9: A victim that was never written is replaced without a write-back.
- R10: A write miss first reads in the block, then merges the byte. Later reads see the written byte and the fetched bytes of the other lanes.
- R11: After reset, req_ready is high and mem_req and resp_valid are low. While a request is in progress, req_ready stays low.
- R12: Cycling through three blocks that map to the same set misses on every access.
- R13: At no time do both ways of the looked-up set hold a valid matching tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Block is idle and can take a request |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Byte to write |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 8 | Byte read (valid with resp_valid on reads) |
| mem_req | output | 1 | Memory transfer request, held until mem_ack |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | ADDR_W-2 | Block address |
| mem_wdata | output | 32 | Block written back |
| mem_ack | input | 1 | Memory completes the transfer this cycle |
| mem_rdata | input | 32 | Block read data, valid with mem_ack |

## Verification
The checks assume a well-behaved memory. It raises mem_ack only while mem_req is high, for one cycle per transfer. They also assume the requester raises req_valid only while req_ready is high. The bench memory model answers each request one cycle after it sees it and drops the acknowledge on the next cycle. The requester task waits for req_ready before it presents an address, and it keeps req_valid high for exactly one cycle. Under these conditions, the property that the two tags never both match holds whenever the refill path is correct.

// File: rtl/c2w_pkg.sv
// Package: shared state encoding and byte-lane helpers for the two-way cache.
// Assumes 32-bit blocks made of four byte lanes.
package c2w_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_WBACK  = 2'd2,
        ST_FILL   = 2'd3
    } c2w_state_e;

    // Extract one byte lane from a block.
    function automatic logic [7:0] lane_get(input logic [31:0] blk, input logic [1:0] lane);
        return blk[{lane, 3'b000} +: 8];
    endfunction

    // Replace one byte lane of a block.
    function automatic logic [31:0] lane_put(input logic [31:0] blk, input logic [1:0] lane,
                                             input logic [7:0] b);
        logic [31:0] r;
        r = blk;
        r[{lane, 3'b000} +: 8] = b;
        return r;
    endfunction

endpackage

// File: rtl/c2w_way_store.sv
// One way of the cache: per-set tag, block data, valid, dirty and recency bit.
// Reads are combinational at rd_set. Fill and write-hit never occur in the same cycle.
module c2w_way_store
    import c2w_pkg::*;
#(
    parameter int SET_W = 4,
    parameter int TAG_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [31:0]      fill_data,
    input  logic             wr_en,
    input  logic [1:0]       wr_lane,
    input  logic [7:0]       wr_byte,
    input  logic             use_set,
    input  logic             use_clr,
    output logic             o_valid,
    output logic             o_dirty,
    output logic             o_use,
    output logic [TAG_W-1:0] o_tag,
    output logic [31:0]      o_data
);
    localparam int SETS = 1 << SET_W;

    logic [TAG_W-1:0] tag_q   [SETS];
    logic [31:0]      data_q  [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic [SETS-1:0]  use_q;

    // Status bits: cleared by reset, updated by fill, write hit and access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            use_q   <= '0;
        end else begin
            if (fill_en) begin
                valid_q[rd_set] <= 1'b1;
                dirty_q[rd_set] <= 1'b0;
            end else if (wr_en) begin
                dirty_q[rd_set] <= 1'b1;
            end
            if (use_set)      use_q[rd_set] <= 1'b1;
            else if (use_clr) use_q[rd_set] <= 1'b0;
        end
    end

    // Payload: tag and block written on refill, one lane merged on write hit.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[rd_set]  <= fill_tag;
            data_q[rd_set] <= fill_data;
        end else if (wr_en) begin
            data_q[rd_set] <= lane_put(data_q[rd_set], wr_lane, wr_byte);
        end
    end

    // Read port for the currently indexed set.
    always_comb begin
        o_valid = valid_q[rd_set];
        o_dirty = dirty_q[rd_set];
        o_use   = use_q[rd_set];
        o_tag   = tag_q[rd_set];
        o_data  = data_q[rd_set];
    end

endmodule

// File: rtl/c2w_hit_cmp.sv
// Parallel tag comparison of both ways of the indexed set.
// Produces a per-way match vector and an encoded hitting way.
module c2w_hit_cmp #(
    parameter int TAG_W = 18,
    parameter int WAYS  = 2
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           look_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit,
    output logic                       hit_way
);
    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid[w] && (tags[w] == look_tag);
    end

    // Reduce to a hit flag and the way index.
    always_comb begin
        hit     = |hit_vec;
        hit_way = hit_vec[1];
    end

endmodule

// File: rtl/c2w_victim_pick.sv
// Chooses the way to refill on a miss: first invalid way (way 0 first),
// otherwise the way whose recency bit is clear.
module c2w_victim_pick (
    input  logic [1:0] valid,
    input  logic [1:0] use_bit,
    input  logic [1:0] dirty,
    output logic       victim,
    output logic       victim_dirty
);
    // Priority: free way 0, free way 1, then least recent.
    always_comb begin
        if (!valid[0])      victim = 1'b0;
        else if (!valid[1]) victim = 1'b1;
        else                victim = use_bit[0];
        victim_dirty = valid[victim] && dirty[victim];
    end

endmodule

// File: rtl/c2w_ctrl.sv
// Request sequencer: accepts a request, looks it up, optionally writes the
// victim back, refills, then repeats the lookup which now hits and completes.
// Assumes mem_ack only arrives while a memory transfer is requested.
module c2w_ctrl
    import c2w_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    input  logic              hit,
    input  logic              victim,
    input  logic              victim_dirty,
    input  logic [31:0]       hit_block,
    input  logic              mem_ack,
    output c2w_state_e        state,
    output logic [ADDR_W-1:0] addr_q,
    output logic              write_q,
    output logic [7:0]        wdata_q,
    output logic              victim_q,
    output logic              resp_valid,
    output logic [7:0]        resp_rdata
);
    c2w_state_e state_q;

    // Sequencer state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:   if (req_valid) state_q <= ST_LOOKUP;
                ST_LOOKUP: begin
                    if (hit)               state_q <= ST_IDLE;
                    else if (victim_dirty) state_q <= ST_WBACK;
                    else                   state_q <= ST_FILL;
                end
                ST_WBACK:  if (mem_ack) state_q <= ST_FILL;
                ST_FILL:   if (mem_ack) state_q <= ST_LOOKUP;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Request capture and victim capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            write_q  <= 1'b0;
            wdata_q  <= '0;
            victim_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                write_q <= req_write;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_LOOKUP && !hit) victim_q <= victim;
        end
    end

    // Completion pulse and read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= (state_q == ST_LOOKUP) && hit;
            if ((state_q == ST_LOOKUP) && hit)
                resp_rdata <= lane_get(hit_block, addr_q[1:0]);
        end
    end

    assign state = state_q;

endmodule

// File: rtl/c2w_cache.sv
// Two-way set-associative write-back, write-allocate byte cache with a
// per-way recency bit. Memory side moves whole 32-bit blocks with a
// request/acknowledge handshake.
module c2w_cache
    import c2w_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SET_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              resp_valid,
    output logic [7:0]        resp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    localparam int OFF_W = 2;
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;
    localparam int WAYS  = 2;

    c2w_state_e              state;
    logic [ADDR_W-1:0]       addr_q;
    logic                    write_q;
    logic [7:0]              wdata_q;
    logic                    victim_q;
    logic [SET_W-1:0]        set_idx;
    logic [TAG_W-1:0]        tag_idx;
    logic [WAYS-1:0]         w_valid, w_dirty, w_use;
    logic [WAYS-1:0][TAG_W-1:0] w_tag;
    logic [WAYS-1:0][31:0]   w_data;
    logic [WAYS-1:0]         hit_vec;
    logic                    hit, hit_way;
    logic                    victim, victim_dirty;
    logic                    lookup_hit, fill_done;

    // Address fields of the request in progress.
    always_comb begin
        set_idx    = addr_q[OFF_W +: SET_W];
        tag_idx    = addr_q[ADDR_W-1 -: TAG_W];
        lookup_hit = (state == ST_LOOKUP) && hit;
        fill_done  = (state == ST_FILL) && mem_ack;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        c2w_way_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_set    (set_idx),
            .fill_en   (fill_done && (victim_q == w[0])),
            .fill_tag  (tag_idx),
            .fill_data (mem_rdata),
            .wr_en     (lookup_hit && hit_vec[w] && write_q),
            .wr_lane   (addr_q[1:0]),
            .wr_byte   (wdata_q),
            .use_set   (lookup_hit && hit_vec[w]),
            .use_clr   (lookup_hit && !hit_vec[w]),
            .o_valid   (w_valid[w]),
            .o_dirty   (w_dirty[w]),
            .o_use     (w_use[w]),
            .o_tag     (w_tag[w]),
            .o_data    (w_data[w])
        );
    end

    c2w_hit_cmp #(.TAG_W(TAG_W), .WAYS(WAYS)) u_cmp (
        .valid    (w_valid),
        .tags     (w_tag),
        .look_tag (tag_idx),
        .hit_vec  (hit_vec),
        .hit      (hit),
        .hit_way  (hit_way)
    );

    c2w_victim_pick u_vic (
        .valid        (w_valid),
        .use_bit      (w_use),
        .dirty        (w_dirty),
        .victim       (victim),
        .victim_dirty (victim_dirty)
    );

    c2w_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .hit          (hit),
        .victim       (victim),
        .victim_dirty (victim_dirty),
        .hit_block    (w_data[hit_way]),
        .mem_ack      (mem_ack),
        .state        (state),
        .addr_q       (addr_q),
        .write_q      (write_q),
        .wdata_q      (wdata_q),
        .victim_q     (victim_q),
        .resp_valid   (resp_valid),
        .resp_rdata   (resp_rdata)
    );

    // Memory side: write-back of the captured victim, else refill of the request.
    always_comb begin
        req_ready = (state == ST_IDLE);
        mem_req   = (state == ST_WBACK) || (state == ST_FILL);
        mem_we    = (state == ST_WBACK);
        mem_addr  = (state == ST_WBACK) ? {w_tag[victim_q], set_idx}
                                        : addr_q[ADDR_W-1:OFF_W];
        mem_wdata = w_data[victim_q];
    end

endmodule

// File: rtl/c2w_cache_chk.sv
// Protocol and consistency checks for c2w_cache, attached by bind.
// Assumes mem_ack is raised only while mem_req is high.
module c2w_cache_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-3:0] mem_addr,
    input logic [1:0]        hit_vec
);
    a_r13_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    a_r2_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r3_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r8_wback_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    a_r3_ack_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack |-> mem_req);

endmodule

bind c2w_cache c2w_cache_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .hit_vec    (hit_vec)
);

// File: tb/c2w_cache_tb.sv
// Directed bench for c2w_cache with a small set count (16 sets, 18-bit tag).
module c2w_cache_tb_top;
    localparam int ADDR_W = 24;
    localparam int SET_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_wdata = '0;
    logic              resp_valid;
    logic [7:0]        resp_rdata;
    logic              mem_req;
    logic              mem_we;
    logic [ADDR_W-3:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic              mem_ack = 1'b0;
    logic [31:0]       mem_rdata = '0;

    always #4 clk = ~clk;   // 125 MHz

    c2w_cache #(.ADDR_W(ADDR_W), .SET_W(SET_W)) dut_i (.*);

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Memory model and expected bytes.
    logic [31:0] mem_blk [logic [21:0]];
    logic [7:0]  truth   [logic [23:0]];
    int          n_fill = 0;
    int          n_wb   = 0;
    logic [21:0] last_wb_addr = '0;
    logic [31:0] last_wb_data = '0;
    bit          fill_after_wb = 1'b0;
    bit          last_was_wb = 1'b0;

    function automatic logic [31:0] seed_blk(input logic [21:0] ba);
        return ({10'd0, ba} * 32'h9E3779B1) + 32'h0135_7BDF;
    endfunction

    function automatic logic [31:0] blk_of(input logic [21:0] ba);
        if (mem_blk.exists(ba)) return mem_blk[ba];
        return seed_blk(ba);
    endfunction

    function automatic logic [7:0] exp_byte(input logic [23:0] a);
        logic [31:0] b;
        if (truth.exists(a)) return truth[a];
        b = seed_blk(a[23:2]);
        return b[{a[1:0], 3'b000} +: 8];
    endfunction

    function automatic logic [23:0] mk(input int tag, input int set, input int lane);
        logic [17:0] t;
        logic [3:0]  s;
        logic [1:0]  l;
        t = tag[17:0]; s = set[3:0]; l = lane[1:0];
        return {t, s, l};
    endfunction

    // Memory responder: acknowledges one negedge after it sees a request.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (rst_n && mem_req) begin
                if (mem_we) begin
                    mem_blk[mem_addr] = mem_wdata;
                    n_wb++;
                    last_wb_addr = mem_addr;
                    last_wb_data = mem_wdata;
                    last_was_wb  = 1'b1;
                end else begin
                    mem_rdata = blk_of(mem_addr);
                    n_fill++;
                    fill_after_wb = last_was_wb;
                    last_was_wb   = 1'b0;
                end
                mem_ack = 1'b1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request; returns read byte and cycles from drive to response.
    task automatic access(input logic wr, input logic [23:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int lat);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        rd = resp_rdata;
        if (wr) truth[a] = d;
        @(negedge clk);
    endtask

    task automatic rd_check(input string req, input logic [23:0] a, input int exp_fills);
        logic [7:0] rd;
        int lat, f0;
        f0 = n_fill;
        access(1'b0, a, 8'h00, rd, lat);
        check({req, " data"}, {24'd0, rd}, {24'd0, exp_byte(a)});
        check({req, " fills"}, n_fill - f0, exp_fills);
    endtask

    task automatic t_reset;
        check("R11 ready", {31'd0, req_ready}, 1);
        check("R11 mem_req", {31'd0, mem_req}, 0);
        check("R11 resp_valid", {31'd0, resp_valid}, 0);
    endtask

    task automatic t_miss_hit;
        logic [7:0] rd;
        int lat, f0, w0;
        rd_check("R3 miss lane2", mk(1, 3, 2), 1);
        check("R3 no wb", n_wb, 0);
        f0 = n_fill; w0 = n_wb;
        access(1'b0, mk(1, 3, 0), 8'h00, rd, lat);
        check("R2 hit data", {24'd0, rd}, {24'd0, exp_byte(mk(1, 3, 0))});
        check("R2 hit latency", lat, 2);
        check("R2 hit no mem", (n_fill - f0) + (n_wb - w0), 0);
        rd_check("R1 lane3", mk(1, 3, 3), 0);
        rd_check("R1 other set same tag", mk(1, 4, 3), 1);
    endtask

    task automatic t_two_ways;
        rd_check("R5 second block free way", mk(2, 3, 1), 1);
        check("R5 no wb", n_wb, 0);
        rd_check("R4 first kept", mk(1, 3, 1), 0);
        rd_check("R4 second kept", mk(2, 3, 0), 0);
    endtask

    task automatic t_lru;
        rd_check("R6 fill A", mk(5, 5, 0), 1);
        rd_check("R6 fill B", mk(6, 5, 0), 1);
        rd_check("R6 touch A", mk(5, 5, 1), 0);
        rd_check("R6 C evicts B", mk(7, 5, 2), 1);
        rd_check("R6 A survives", mk(5, 5, 2), 0);
        rd_check("R6 B was evicted", mk(6, 5, 3), 1);
        rd_check("R6 C was evicted", mk(7, 5, 0), 1);
    endtask

    task automatic t_write;
        logic [7:0] rd;
        int lat, f0, w0;
        f0 = n_fill; w0 = n_wb;
        access(1'b1, mk(9, 9, 1), 8'h3C, rd, lat);
        check("R10 write miss fills", n_fill - f0, 1);
        check("R10 no wb", n_wb - w0, 0);
        rd_check("R10 merged byte", mk(9, 9, 1), 0);
        rd_check("R10 fetched lane", mk(9, 9, 2), 0);
        f0 = n_fill; w0 = n_wb;
        access(1'b1, mk(9, 9, 3), 8'hE7, rd, lat);
        check("R7 write hit no mem", (n_fill - f0) + (n_wb - w0), 0);
        rd_check("R7 read back", mk(9, 9, 3), 0);
        rd_check("R9 fill B", mk(10, 9, 0), 1);
        rd_check("R9 touch A", mk(9, 9, 0), 0);
        w0 = n_wb;
        rd_check("R9 C evicts clean B", mk(11, 9, 0), 1);
        check("R9 no wb of clean", n_wb - w0, 0);
        w0 = n_wb;
        rd_check("R8 B evicts dirty A", mk(10, 9, 2), 1);
        check("R8 one wb", n_wb - w0, 1);
        check("R8 wb addr", {10'd0, last_wb_addr}, {10'd0, mk(9, 9, 0) >> 2});
        check("R8 wb lane1", {24'd0, last_wb_data[15:8]}, 32'h3C);
        check("R8 wb lane3", {24'd0, last_wb_data[31:24]}, 32'hE7);
        check("R8 wb before fill", {31'd0, fill_after_wb}, 1);
        rd_check("R8 memory holds write", mk(9, 9, 1), 1);
    endtask

    task automatic t_thrash;
        int f0;
        f0 = n_fill;
        for (int k = 0; k < 6; k++) rd_check("R12 cycle", mk(20 + (k % 3), 11, k % 4), 1);
        check("R12 total fills", n_fill - f0, 6);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_hit();
        t_two_ways();
        t_lru();
        t_write();
        t_thrash();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule